// File: doc/BRIEF.md
# Current-Sense Converter Sequencer

This block is the digital control around a current-sense sigma-delta converter that is used to count battery charge. It decides when the converter is powered and drops the settling conversions that follow each restart. It takes the raw instantaneous and accumulate results that the converter reports as valid strobes with data. From those results it keeps the result registers and two sticky interrupt flags. The analog modulator, the decimation filters and the voltage reference are outside the block.

In continuous operation every accepted accumulate result is stored and raises the accumulate interrupt. Every accepted instantaneous result is compared by magnitude with a programmable threshold. When the sampling enable is set, the block runs a duty cycle. It powers the converter until one accepted instantaneous result arrives, switches the converter off for a selectable interval, and then wakes it again. Power-down and power-off modes halt the converter. When the block returns from them it resumes continuous operation by itself. The 32-bit accumulate result is read one byte at a time. Reading byte 0 takes a snapshot of the whole word, so the four bytes always belong together.

Top module: `ccadc_seq`

## Requirements
- R1: While `en` is 0, `conv_run` is 0 and result strobes change no flag and no result register.
- R2: After each rising edge of `conv_run`, the first four clock cycles that carry `inst_vld` or `acc_vld` are discarded. The fifth such cycle is accepted, and its flags and registers are updated at that clock edge.
- R3: A falling edge of `samp_en` restarts the four-conversion discard, even though `conv_run` stays high.
- R4: With `samp_en` = 1, an accepted instantaneous result drives `conv_run` low at that clock edge. `conv_run` stays low for exactly OFF_BASE << `isel` cycles (16, 32, 64 or 128 by default for `isel` 0 to 3) and then returns high. After it returns high, the discard of R2 applies again.
- R5: An accepted instantaneous result sets `irq_thr` when its two's-complement magnitude is strictly greater than the unsigned value `thr`. A magnitude equal to `thr` does not set it. The value -32768 has magnitude 32768.
- R6: An accepted accumulate result is stored and sets `irq_acc`. `irq_acc` and `irq_thr` stay set until `clr_acc` or `clr_thr` is pulsed. If a set and a clear of the same flag happen in one cycle, the set wins.
- R7: A pulse of `rd_en` presents a byte on `rd_data` one cycle later. `rd_sel` = 0 snapshots the stored accumulate word and returns bits 7:0. `rd_sel` = 1, 2 and 3 return bits 15:8, 23:16 and 31:24 of the snapshot, even when a newer result has been stored since.
- R8: `pwr_mode` 2 (power-down) or 3 (power-off) drives `conv_run` low at the next edge, and results are ignored while halted. Returning to mode 0 or 1 raises `conv_run` again with the discard of R2.
- R9: In `pwr_mode` 1 (sleep), the converter keeps running and threshold detection works as it does in mode 0.
- R10: `conv_period` follows `psel` one cycle later. The codes 0, 1, 2 and 3 select accumulate periods of 125, 250, 500 and 1000 ms.
- R11: While `samp_en` = 1, accumulate strobes neither set `irq_acc` nor change the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| samp_en | input | 1 | Duty-cycled sampling enable |
| isel | input | 2 | Off-interval select |
| psel | input | 2 | Accumulate period select |
| thr | input | IW | Unsigned magnitude threshold |
| pwr_mode | input | 2 | 0 active, 1 sleep, 2 power-down, 3 power-off |
| inst_vld | input | 1 | Instantaneous result strobe |
| inst_data | input | IW | Instantaneous result, two's complement |
| acc_vld | input | 1 | Accumulate result strobe |
| acc_data | input | AW | Accumulate result |
| clr_acc | input | 1 | Clear accumulate flag (write 1) |
| clr_thr | input | 1 | Clear threshold flag (write 1) |
| rd_en | input | 1 | Byte read strobe |
| rd_sel | input | SW | Byte index |
| conv_run | output | 1 | Converter power/run request |
| conv_period | output | 2 | Period select to converter |
| inst_res | output | IW | Last accepted instantaneous result |
| irq_acc | output | 1 | Accumulate interrupt flag |
| irq_thr | output | 1 | Threshold interrupt flag |
| rd_data | output | 8 | Read byte |

## Verification
Flags, `inst_res` and the stored accumulate word change at the same edge that samples an accepted strobe. `conv_run` reacts one edge after a change to `en`, `samp_en` or `pwr_mode`, and it falls at the edge that accepts a duty-cycle result. `rd_data` and `conv_period` settle one edge after their inputs. The bench drives every input on the falling clock edge and holds each strobe for a single cycle. It reads outputs on the following falling edge, so each check falls in the first half-cycle after the edge that updated the output. For the off interval, the bench counts exactly OFF_BASE << `isel` minus one edges and checks that `conv_run` is still low. It then checks one edge later that `conv_run` is high.

// File: rtl/ccadc_pkg.sv
package ccadc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_DOWN   = 2'd2,
    PM_OFF    = 2'd3
  } pmode_e;

  localparam int unsigned DISCARD_N = 4;

  function automatic logic is_halt(input logic [1:0] m);
    return (m == PM_DOWN) || (m == PM_OFF);
  endfunction
endpackage

// File: rtl/ccadc_settle.sv
module ccadc_settle #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic strobe,
  output logic ready
);
  localparam int unsigned CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (strobe && (cnt != CW'(N))) cnt <= cnt + 1'b1;
  end

  assign ready = run && !restart && (cnt == CW'(N));

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/ccadc_duty.sv
module ccadc_duty #(
  parameter int unsigned OFF_BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       halt,
  input  logic       samp_en,
  input  logic [1:0] isel,
  input  logic       inst_ok,
  output logic       run
);
  localparam int unsigned OCW = $clog2(OFF_BASE * 8 + 1);
  logic [OCW-1:0] off_cnt;
  logic [OCW-1:0] off_len;
  logic           sleeping;

  assign off_len = OCW'(OFF_BASE) << isel;

  always_ff @(posedge clk) begin
    if (rst || !en || halt) begin
      run      <= 1'b0;
      sleeping <= 1'b0;
      off_cnt  <= '0;
    end else if (!samp_en) begin
      run      <= 1'b1;
      sleeping <= 1'b0;
    end else if (sleeping) begin
      if (off_cnt == '0) begin
        sleeping <= 1'b0;
        run      <= 1'b1;
      end else begin
        off_cnt <= off_cnt - 1'b1;
      end
    end else if (inst_ok) begin
      sleeping <= 1'b1;
      run      <= 1'b0;
      off_cnt  <= off_len - 1'b1;
    end else begin
      run <= 1'b1;
    end
  end

  // R1
  run_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !run);
  // R8
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !run);
  // R4
  wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(run) && $past(en && samp_en && !halt)) |-> $past(inst_ok));
endmodule

// File: rtl/ccadc_readout.sv
module ccadc_readout #(
  parameter int unsigned AW = 32,
  localparam int unsigned NB = AW / 8,
  localparam int unsigned SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] word,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sel,
  output logic [7:0]    rd_data
);
  logic [AW-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_sel == '0) begin
        snap    <= word;
        rd_data <= word[7:0];
      end else begin
        rd_data <= snap[rd_sel*8 +: 8];
      end
    end
  end

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_sel == '0) |=> $stable(snap));
endmodule

// File: rtl/ccadc_seq.sv
module ccadc_seq
  import ccadc_pkg::*;
#(
  parameter int unsigned IW       = 16,
  parameter int unsigned AW       = 32,
  parameter int unsigned OFF_BASE = 16,
  localparam int unsigned NB = AW / 8,
  localparam int unsigned SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          samp_en,
  input  logic [1:0]    isel,
  input  logic [1:0]    psel,
  input  logic [IW-1:0] thr,
  input  logic [1:0]    pwr_mode,
  input  logic          inst_vld,
  input  logic [IW-1:0] inst_data,
  input  logic          acc_vld,
  input  logic [AW-1:0] acc_data,
  input  logic          clr_acc,
  input  logic          clr_thr,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sel,
  output logic          conv_run,
  output logic [1:0]    conv_period,
  output logic [IW-1:0] inst_res,
  output logic          irq_acc,
  output logic          irq_thr,
  output logic [7:0]    rd_data
);
  logic          samp_q;
  logic          samp_fall;
  logic          halt;
  logic          ready;
  logic          inst_ok;
  logic          acc_ok;
  logic [IW:0]   ext;
  logic [IW:0]   mag;
  logic          over;
  logic [AW-1:0] acc_word;

  assign halt      = is_halt(pwr_mode);
  assign samp_fall = samp_q && !samp_en;
  assign inst_ok   = ready && inst_vld;
  assign acc_ok    = ready && acc_vld && !samp_en;
  assign ext       = {inst_data[IW-1], inst_data};
  assign mag       = ext[IW] ? (~ext + 1'b1) : ext;
  assign over      = mag > {1'b0, thr};

  ccadc_settle #(.N(DISCARD_N)) u_settle (
    .clk(clk), .rst(rst), .run(conv_run), .restart(samp_fall),
    .strobe(inst_vld || acc_vld), .ready(ready)
  );

  ccadc_duty #(.OFF_BASE(OFF_BASE)) u_duty (
    .clk(clk), .rst(rst), .en(en), .halt(halt), .samp_en(samp_en),
    .isel(isel), .inst_ok(inst_ok), .run(conv_run)
  );

  ccadc_readout #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .word(acc_word), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q      <= 1'b0;
      conv_period <= '0;
      inst_res    <= '0;
      acc_word    <= '0;
      irq_acc     <= 1'b0;
      irq_thr     <= 1'b0;
    end else begin
      samp_q      <= samp_en;
      conv_period <= psel;
      if (inst_ok) inst_res <= inst_data;
      if (acc_ok)  acc_word <= acc_data;
      if (clr_acc) irq_acc <= 1'b0;
      if (acc_ok)  irq_acc <= 1'b1;
      if (clr_thr) irq_thr <= 1'b0;
      if (inst_ok && over) irq_thr <= 1'b1;
    end
  end

  // R5
  thr_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_thr) |-> $past(inst_vld && conv_run));
  // R6
  acc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_acc && !clr_acc) |=> irq_acc);
  // R11
  acc_duty_chk: assert property (@(posedge clk) disable iff (rst)
    samp_en |=> $stable(acc_word));
endmodule

// File: tb/ccadc_seq_tb.sv
module ccadc_seq_tb;
  localparam int CLK_PER = 10;
  localparam int OFFB    = 16;

  logic        clk = 0, rst = 1;
  logic        en = 0, samp_en = 0;
  logic [1:0]  isel = 0, psel = 0, pwr_mode = 0, rd_sel = 0;
  logic [15:0] thr = 16'd100, inst_data = 0;
  logic        inst_vld = 0, acc_vld = 0, clr_acc = 0, clr_thr = 0, rd_en = 0;
  logic [31:0] acc_data = 0;
  logic        conv_run, irq_acc, irq_thr;
  logic [1:0]  conv_period;
  logic [15:0] inst_res;
  logic [7:0]  rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  ccadc_seq #(.OFF_BASE(OFFB)) u_dut (
    .clk(clk), .rst(rst), .en(en), .samp_en(samp_en), .isel(isel),
    .psel(psel), .thr(thr), .pwr_mode(pwr_mode), .inst_vld(inst_vld),
    .inst_data(inst_data), .acc_vld(acc_vld), .acc_data(acc_data),
    .clr_acc(clr_acc), .clr_thr(clr_thr), .rd_en(rd_en), .rd_sel(rd_sel),
    .conv_run(conv_run), .conv_period(conv_period), .inst_res(inst_res),
    .irq_acc(irq_acc), .irq_thr(irq_thr), .rd_data(rd_data)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic p_inst(input logic [15:0] d);
    inst_data = d; inst_vld = 1; tick(); inst_vld = 0;
  endtask

  task automatic p_acc(input logic [31:0] d);
    acc_data = d; acc_vld = 1; tick(); acc_vld = 0;
  endtask

  task automatic clear_flags();
    clr_acc = 1; clr_thr = 1; tick(); clr_acc = 0; clr_thr = 0;
  endtask

  task automatic rd_byte(input logic [1:0] s, input logic [7:0] exp, input string req);
    rd_sel = s; rd_en = 1; tick(); rd_en = 0;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset run", conv_run, 0);
    chk("R6 reset irq_acc", irq_acc, 0);
    chk("R6 reset irq_thr", irq_thr, 0);
    chk("R7 reset rd_data", rd_data, 0);
  endtask

  task automatic t_disabled();
    for (int i = 0; i < 6; i++) p_acc(32'hDEAD0000 + i);
    for (int i = 0; i < 6; i++) p_inst(16'h7000);
    chk("R1 run low", conv_run, 0);
    chk("R1 irq_acc", irq_acc, 0);
    chk("R1 irq_thr", irq_thr, 0);
    chk("R1 inst_res", inst_res, 0);
  endtask

  task automatic t_settle();
    en = 1; tick();
    chk("R2 run up", conv_run, 1);
    for (int i = 0; i < 4; i++) p_inst(16'h7000);
    chk("R2 discarded", irq_thr, 0);
    chk("R2 inst_res kept", inst_res, 0);
    p_inst(16'h7000);
    chk("R2 fifth accepted", irq_thr, 1);
    chk("R2 fifth result", inst_res, 16'h7000);
    clear_flags();
    chk("R6 clr_thr", irq_thr, 0);
  endtask

  task automatic t_threshold();
    p_inst(16'd100);  chk("R5 equal", irq_thr, 0);
    p_inst(16'd101);  chk("R5 above", irq_thr, 1);
    clear_flags();
    p_inst(16'hFF9B); chk("R5 neg -101", irq_thr, 1);
    clear_flags();
    p_inst(16'hFF9C); chk("R5 neg -100", irq_thr, 0);
    p_inst(16'h8000); chk("R5 min neg", irq_thr, 1);
    clear_flags();
  endtask

  task automatic t_accum();
    p_acc(32'h12345678); chk("R6 set", irq_acc, 1);
    tick();              chk("R6 sticky", irq_acc, 1);
    clr_acc = 1; tick(); clr_acc = 0;
    chk("R6 cleared", irq_acc, 0);
    clr_acc = 1; p_acc(32'hA1B2C3D4); clr_acc = 0;
    chk("R6 set wins", irq_acc, 1);
    clear_flags();
  endtask

  task automatic t_readout();
    rd_byte(0, 8'hD4, "R7 byte0");
    p_acc(32'h11223344);
    rd_byte(1, 8'hC3, "R7 byte1 snap");
    rd_byte(2, 8'hB2, "R7 byte2 snap");
    rd_byte(3, 8'hA1, "R7 byte3 snap");
    rd_byte(0, 8'h44, "R7 new snap");
    rd_byte(3, 8'h11, "R7 new byte3");
    clear_flags();
  endtask

  task automatic t_period();
    psel = 2; tick(); chk("R10 period 2", conv_period, 2);
    psel = 3; tick(); chk("R10 period 3", conv_period, 3);
  endtask

  task automatic t_sleep();
    pwr_mode = 1; tick();
    chk("R9 run in sleep", conv_run, 1);
    p_inst(16'd500);
    chk("R9 thr in sleep", irq_thr, 1);
    clear_flags();
    pwr_mode = 0; tick();
  endtask

  task automatic t_powerdown();
    pwr_mode = 2; tick();
    chk("R8 down halts", conv_run, 0);
    p_inst(16'd500);
    chk("R8 ignored", irq_thr, 0);
    pwr_mode = 0; tick();
    chk("R8 resume", conv_run, 1);
    for (int i = 0; i < 4; i++) p_inst(16'd500);
    chk("R8 discard", irq_thr, 0);
    p_inst(16'd500);
    chk("R8 accepted", irq_thr, 1);
    clear_flags();
    pwr_mode = 3; tick();
    chk("R8 off halts", conv_run, 0);
    pwr_mode = 0; tick();
    for (int i = 0; i < 4; i++) p_inst(16'd600);
    p_inst(16'd33);
    chk("R8 resume value", inst_res, 16'd33);
  endtask

  task automatic t_samp_clear();
    samp_en = 1; tick();
    samp_en = 0; tick();
    chk("R3 still running", conv_run, 1);
    for (int i = 0; i < 4; i++) p_inst(16'h7000);
    chk("R3 discard", irq_thr, 0);
    p_inst(16'h7000);
    chk("R3 accepted", irq_thr, 1);
    clear_flags();
  endtask

  task automatic t_duty();
    int unsigned len;
    isel = 1; len = OFFB << 1;
    samp_en = 1; tick();
    p_acc(32'h00000005);
    chk("R11 acc ignored", irq_acc, 0);
    rd_byte(0, 8'h44, "R11 word kept");
    p_inst(16'd10);
    chk("R4 result", inst_res, 16'd10);
    chk("R4 off", conv_run, 0);
    for (int i = 0; i < int'(len) - 1; i++) tick();
    chk("R4 still off", conv_run, 0);
    tick();
    chk("R4 wake", conv_run, 1);
    for (int i = 0; i < 4; i++) p_inst(16'h7000);
    chk("R4 wake discard", irq_thr, 0);
    chk("R4 run during discard", conv_run, 1);
    p_inst(16'd20);
    chk("R4 second result", inst_res, 16'd20);
    chk("R4 off again", conv_run, 0);
    samp_en = 0; tick();
    chk("R4 leave duty", conv_run, 1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0; tick();
    t_reset();
    t_disabled();
    t_settle();
    t_threshold();
    t_accum();
    t_readout();
    t_period();
    t_sleep();
    t_powerdown();
    t_samp_clear();
    t_duty();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule